// File: doc/BRIEF.md
# Receive Channel Input Enable Gate

This block sits at the head of one receive channel. It picks one of two wideband input ports, each carrying a 14-bit sample, a 3-bit exponent and an enable line. On every clock it then decides whether the current sample enters the filter chain, is replaced by zero, or is dropped. It also decides whether the channel's NCO phase accumulator should step, and it routes one of four external sync pins to the channel. The NCO and the filters are outside this block. A run strobe tells the back end to keep working on every clock, whatever the enable line does.

A 9-bit configuration word drives the block. Bits 1:0 hold the enable mode, bit 6 picks the input port, and bits 8:7 pick the sync pin. The sample output is a stream with a valid strobe only. There is no ready line and no back-pressure. The downstream chain must take every beat in the cycle it appears. A beat that is not taken is lost.

Each decision uses the inputs present at a rising clock edge. The result appears at the outputs after that same edge, one register deep. In the two edge modes, the block compares the selected enable with a copy of it registered one clock earlier. That registered copy is loaded with the current level while reset is held, so no edge is seen straight after reset.

Top module: `rx_input_gate`

## Requirements
- R1: The mode field is cfg_word[1:0]. 0 is blanking, 1 is level-gated, 2 is rising-edge single capture and 3 is falling-edge single capture. While rst_n is low at a clock edge, smp_valid, nco_adv, smp_data, smp_exp and backend_run all become 0 after that edge.
- R2: In mode 0, smp_valid and nco_adv are 1 after every clock edge. The delivered data and exponent equal the selected port's inputs when its enable was high at that edge, and are both zero when it was low.
- R3: In mode 1, an edge where the selected enable is high gives smp_valid=1 and nco_adv=1, and the data and exponent are taken from that edge. An edge where the enable is low gives smp_valid=0 and nco_adv=0, and smp_data and smp_exp keep their previous values.
- R4: In mode 2, a sample is taken only at an edge where the selected enable is high and was low at the previous edge. That edge gives one cycle of smp_valid=1 and nco_adv=1. At all other edges both are 0 and the held data does not change.
- R5: In mode 3, a sample is taken only at an edge where the selected enable is low and was high at the previous edge. Valid, advance and hold behave as in R4.
- R6: cfg_word[6]=1 selects port B's data, exponent and enable. cfg_word[6]=0 selects port A's. The port that is not selected has no effect on any output.
- R7: cfg_word[8:7] picks the sync pin as an index into sync_pins: 0 is A (bit 0), 1 is B, 2 is C and 3 is D (bit 3). sync_out follows the chosen pin combinationally.
- R8: backend_run is 1 after every clock edge at which rst_n is high, in every mode and for every enable level.
- R9: The registered enable copy takes the current enable level during reset. So in modes 2 and 3, the first edge after reset release captures only if the enable changed since the last reset edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_word | input | 9 | Channel configuration: mode [1:0], port select [6], sync select [8:7] |
| a_data | input | 14 | Port A sample |
| a_exp | input | 3 | Port A exponent |
| a_en | input | 1 | Port A enable |
| b_data | input | 14 | Port B sample |
| b_exp | input | 3 | Port B exponent |
| b_en | input | 1 | Port B enable |
| sync_pins | input | 4 | External sync pins A to D, bit 0 is A |
| smp_data | output | 14 | Sample to filter chain |
| smp_exp | output | 3 | Exponent to filter chain |
| smp_valid | output | 1 | Sample beat strobe, no back-pressure |
| nco_adv | output | 1 | NCO phase accumulator step strobe |
| sync_out | output | 1 | Selected sync pin |
| backend_run | output | 1 | Back-end processing enable |

## Verification
Most internal faults show up on the cycle right after the edge that exposes them. A stale or wrongly reset enable copy causes a missing or extra capture strobe one cycle after reset release, or at the next enable transition in the edge modes. A broken hold register in the gated modes shows up as data changing while smp_valid is low. A port-mux or blank fault shows as wrong data on the very next beat. The bench sweeps every mode against both ports and several enable patterns, with a reset before each combination. It also sweeps every sync selection against all pin values.

// File: rtl/rxg_pkg.sv
package rxg_pkg;
  typedef enum logic [1:0] {
    GATE_BLANK = 2'd0,
    GATE_LEVEL = 2'd1,
    GATE_RISE  = 2'd2,
    GATE_FALL  = 2'd3
  } gate_mode_e;
endpackage

// File: rtl/rxg_port_mux.sv
module rxg_port_mux #(
  parameter int DATA_W = 14,
  parameter int EXP_W  = 3
) (
  input  logic              pick_b,
  input  logic [DATA_W-1:0] a_data,
  input  logic [EXP_W-1:0]  a_exp,
  input  logic              a_en,
  input  logic [DATA_W-1:0] b_data,
  input  logic [EXP_W-1:0]  b_exp,
  input  logic              b_en,
  output logic [DATA_W-1:0] sel_data,
  output logic [EXP_W-1:0]  sel_exp,
  output logic              sel_en
);
  always_comb begin
    if (pick_b) begin
      sel_data = b_data;
      sel_exp  = b_exp;
      sel_en   = b_en;
    end else begin
      sel_data = a_data;
      sel_exp  = a_exp;
      sel_en   = a_en;
    end
  end
endmodule

// File: rtl/rxg_sync_mux.sv
module rxg_sync_mux #(
  parameter int NUM_SYNC = 4,
  localparam int SEL_W = (NUM_SYNC > 1) ? $clog2(NUM_SYNC) : 1
) (
  input  logic [NUM_SYNC-1:0] pins,
  input  logic [SEL_W-1:0]    sel,
  output logic                sync_o
);
  logic [NUM_SYNC-1:0] hit;
  genvar gi;
  generate
    for (gi = 0; gi < NUM_SYNC; gi++) begin : g_tap
      assign hit[gi] = pins[gi] && (sel == gi[SEL_W-1:0]);
    end
  endgenerate
  assign sync_o = |hit;
endmodule

// File: rtl/rxg_edge_det.sv
module rxg_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic rise_o,
  output logic fall_o
);
  logic en_q;

  // During reset the copy tracks the live level, so release brings no edge.
  always_ff @(posedge clk) begin
    en_q <= en_i;
  end

  assign rise_o = rst_n &&  en_i && !en_q;
  assign fall_o = rst_n && !en_i &&  en_q;

  a_r9_no_double_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
  a_r9_no_double_fall: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);
endmodule

// File: rtl/rxg_gate_core.sv
module rxg_gate_core
  import rxg_pkg::*;
#(
  parameter int DATA_W = 14,
  parameter int EXP_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  gate_mode_e        mode_i,
  input  logic [DATA_W-1:0] din,
  input  logic [EXP_W-1:0]  ein,
  input  logic              en_i,
  input  logic              rise_i,
  input  logic              fall_i,
  output logic [DATA_W-1:0] dout,
  output logic [EXP_W-1:0]  eout,
  output logic              valid_o,
  output logic              adv_o,
  output logic              run_o
);
  logic take, blank, step;

  always_comb begin
    take  = 1'b0;
    blank = 1'b0;
    step  = 1'b0;
    unique case (mode_i)
      GATE_BLANK: begin take = 1'b1;   blank = !en_i; step = 1'b1;   end
      GATE_LEVEL: begin take = en_i;   step  = en_i;                 end
      GATE_RISE:  begin take = rise_i; step  = rise_i;               end
      GATE_FALL:  begin take = fall_i; step  = fall_i;               end
      default:    begin take = 1'b0;   step  = 1'b0;                 end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout    <= '0;
      eout    <= '0;
      valid_o <= 1'b0;
      adv_o   <= 1'b0;
      run_o   <= 1'b0;
    end else begin
      valid_o <= take;
      adv_o   <= step;
      run_o   <= 1'b1;
      if (take) begin
        dout <= blank ? '0 : din;
        eout <= blank ? '0 : ein;
      end
    end
  end

  a_r2_blank_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == GATE_BLANK && !en_i) |=> (valid_o && adv_o && dout == '0 && eout == '0));
  a_r2_blank_free_nco: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == GATE_BLANK) |=> adv_o);
  a_r3_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == GATE_LEVEL && !en_i) |=> (!valid_o && !adv_o && $stable(dout)));
  a_r4_rise_needs_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == GATE_RISE && !en_i) |=> (!valid_o && !adv_o));
  a_r5_fall_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == GATE_FALL && en_i) |=> (!valid_o && !adv_o));
  a_r8_run_on: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> run_o);
endmodule

// File: rtl/rx_input_gate.sv
module rx_input_gate
  import rxg_pkg::*;
#(
  parameter int DATA_W   = 14,
  parameter int EXP_W    = 3,
  parameter int NUM_SYNC = 4,
  parameter int CFG_W    = 9,
  parameter int MODE_LSB = 0,
  parameter int PORT_BIT = 6,
  parameter int SYNC_LSB = 7,
  localparam int SYNC_W  = (NUM_SYNC > 1) ? $clog2(NUM_SYNC) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CFG_W-1:0]    cfg_word,
  input  logic [DATA_W-1:0]   a_data,
  input  logic [EXP_W-1:0]    a_exp,
  input  logic                a_en,
  input  logic [DATA_W-1:0]   b_data,
  input  logic [EXP_W-1:0]    b_exp,
  input  logic                b_en,
  input  logic [NUM_SYNC-1:0] sync_pins,
  output logic [DATA_W-1:0]   smp_data,
  output logic [EXP_W-1:0]    smp_exp,
  output logic                smp_valid,
  output logic                nco_adv,
  output logic                sync_out,
  output logic                backend_run
);
  gate_mode_e        mode;
  logic [DATA_W-1:0] sel_data;
  logic [EXP_W-1:0]  sel_exp;
  logic              sel_en, rise, fall;

  assign mode = gate_mode_e'(cfg_word[MODE_LSB +: 2]);

  rxg_port_mux #(.DATA_W(DATA_W), .EXP_W(EXP_W)) u_port (
    .pick_b(cfg_word[PORT_BIT]),
    .a_data(a_data), .a_exp(a_exp), .a_en(a_en),
    .b_data(b_data), .b_exp(b_exp), .b_en(b_en),
    .sel_data(sel_data), .sel_exp(sel_exp), .sel_en(sel_en)
  );

  rxg_sync_mux #(.NUM_SYNC(NUM_SYNC)) u_sync (
    .pins(sync_pins),
    .sel(cfg_word[SYNC_LSB +: SYNC_W]),
    .sync_o(sync_out)
  );

  rxg_edge_det u_edge (
    .clk(clk), .rst_n(rst_n), .en_i(sel_en),
    .rise_o(rise), .fall_o(fall)
  );

  rxg_gate_core #(.DATA_W(DATA_W), .EXP_W(EXP_W)) u_core (
    .clk(clk), .rst_n(rst_n), .mode_i(mode),
    .din(sel_data), .ein(sel_exp), .en_i(sel_en),
    .rise_i(rise), .fall_i(fall),
    .dout(smp_data), .eout(smp_exp),
    .valid_o(smp_valid), .adv_o(nco_adv), .run_o(backend_run)
  );

  a_r4_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == GATE_RISE && smp_valid) |=> !smp_valid);
  a_r5_single_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == GATE_FALL && smp_valid) |=> !smp_valid);
  a_r1_strobes_agree: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid == nco_adv));
endmodule

// File: tb/rx_input_gate_tb.sv
module rx_input_gate_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  cfg_word = '0;
  logic [13:0] a_data = '0, b_data = '0;
  logic [2:0]  a_exp = '0, b_exp = '0;
  logic        a_en = 1'b0, b_en = 1'b0;
  logic [3:0]  sync_pins = '0;
  logic [13:0] smp_data;
  logic [2:0]  smp_exp;
  logic        smp_valid, nco_adv, sync_out, backend_run;

  int total = 0, bad = 0;
  bit done = 0;

  // expected state
  logic        m_prev;
  logic [13:0] m_data;
  logic [2:0]  m_exp;

  always #10 clk = ~clk;

  rx_input_gate u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word),
    .a_data(a_data), .a_exp(a_exp), .a_en(a_en),
    .b_data(b_data), .b_exp(b_exp), .b_en(b_en),
    .sync_pins(sync_pins),
    .smp_data(smp_data), .smp_exp(smp_exp), .smp_valid(smp_valid),
    .nco_adv(nco_adv), .sync_out(sync_out), .backend_run(backend_run)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input bit port_b, input logic en, input logic [13:0] d, input logic [2:0] e);
    if (port_b) begin
      b_en = en; b_data = d; b_exp = e;
      a_en = ~en; a_data = ~d; a_exp = ~e;
    end else begin
      a_en = en; a_data = d; a_exp = e;
      b_en = ~en; b_data = ~d; b_exp = ~e;
    end
  endtask

  task automatic do_reset(input bit port_b, input logic en0);
    rst_n = 1'b0;
    drive(port_b, en0, 14'h1555, 3'd5);
    repeat (2) @(negedge clk);
    chk("R1 valid", smp_valid, 0);
    chk("R1 adv", nco_adv, 0);
    chk("R1 data", smp_data, 0);
    chk("R1 exp", smp_exp, 0);
    chk("R1 run", backend_run, 0);
    m_prev = en0; m_data = '0; m_exp = '0;
    rst_n = 1'b1;
  endtask

  task automatic step(input int mode, input bit port_b, input logic en,
                      input logic [13:0] d, input logic [2:0] e);
    logic take, zero;
    string tag;
    drive(port_b, en, d, e);
    zero = 1'b0;
    case (mode)
      0: begin take = 1'b1; zero = !en; end
      1: take = en;
      2: take = en && !m_prev;
      default: take = !en && m_prev;
    endcase
    m_prev = en;
    if (take) begin
      m_data = zero ? 14'd0 : d;
      m_exp  = zero ? 3'd0 : e;
    end
    case (mode)
      0: tag = "R2";
      1: tag = "R3";
      2: tag = "R4";
      default: tag = "R5";
    endcase
    @(negedge clk);
    chk({tag, " valid"}, smp_valid, take);
    chk({tag, " adv"}, nco_adv, take);
    chk({tag, port_b ? " R6 data B" : " R6 data A"}, smp_data, m_data);
    chk({tag, " exp"}, smp_exp, m_exp);
    chk("R8 run", backend_run, 1);
  endtask

  initial begin
    logic [15:0] pats [3];
    pats[0] = 16'b0110_1110_0010_1011;
    pats[1] = 16'hF0F0;
    pats[2] = 16'h5A3C;
    @(negedge clk);
    for (int md = 0; md < 4; md++) begin
      for (int pb = 0; pb < 2; pb++) begin
        for (int p = 0; p < 3; p++) begin
          cfg_word = '0;
          cfg_word[1:0] = md[1:0];
          cfg_word[6] = pb[0];
          // R9: reset level is the pattern's first bit; step 0 repeats it
          do_reset(pb[0], pats[p][0]);
          for (int c = 0; c < 16; c++) begin
            step(md, pb[0], pats[p][c],
                 14'((c * 613 + md * 97 + pb * 41 + p * 7 + 1) & 14'h3FFF),
                 3'((c + md + p) & 7));
          end
        end
      end
      // R9: reset at low, release with enable high -> rise mode captures at once
      cfg_word = '0; cfg_word[1:0] = md[1:0];
      do_reset(1'b0, 1'b0);
      step(md, 1'b0, 1'b1, 14'h2AAA, 3'd3);
      step(md, 1'b0, 1'b0, 14'h0123, 3'd1);
    end
    // R7 sync selection sweep
    for (int s = 0; s < 4; s++) begin
      for (int v = 0; v < 16; v++) begin
        cfg_word[8:7] = s[1:0];
        sync_pins = v[3:0];
        #1;
        chk("R7 sync", sync_out, v[s]);
      end
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=hung exp=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule